// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch Sequencer

This block is the control heart of a small 32-bit integer core whose instruction memory sits behind an 8-bit bus. Every instruction is pulled in one byte per cycle, lowest byte first, over four phases. While the bytes arrive, the sequencer pulls the destination index and a legality flag out of the first two bytes, and it strobes the register-file read port for the first source operand in phase 3 and for the second in phase 4. The completed instruction is handed to the execute logic during phase 1 of the next instruction, and its result is written back during phase 2. Reads fall only in phases 3 and 4 and writes only in phases 1 and 2, so a single-port block RAM can hold the registers without any hazard logic.

Two events bend the normal rhythm. A taken jump or branch, reported by the execute logic in the cycle the instruction executes, discards the byte just fetched and restarts phase 1 at the target, which costs one cycle. A load or store parks the sequencer in phase 4 until the data access reports completion; the next instruction's fetch pointer stays put meanwhile. A plain `hold` input freezes all state and masks every strobe, which is how a slow peripheral applies back-pressure to the whole core. The memory bus itself is plain: the byte at `mem_addr` is expected on `mem_rdata` in the same cycle.

Top module: `byte_fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter becomes 0 and the phase becomes phase 1 (`phase_o` = 0); with no pending work, `exec_valid_o`, `rf_we_o` and `rf_rd_en_o` are low.
- R2: `mem_addr` is the low `ADDR_W` bits of a 32-bit program counter that advances by one per fetched byte; the bytes fetched at addresses A, A+1, A+2, A+3 form the instruction little-endian, so after a non-jump instruction the counter equals its start value plus four.
- R3: Without hold, stall or redirect, `phase_o` steps 0, 1, 2, 3, 0 (phases 1 to 4), one step per clock.
- R4: In phase 2, `dec_rd_o` shows instruction bits [11:7] and `dec_legal_o` is high only for major opcodes 0x37, 0x17, 0x6F, 0x67, 0x63, 0x03, 0x23, 0x13, 0x33, 0x0F and 0x73 (bits [6:0]).
- R5: `rf_rd_en_o` rises only in phase 3 with `rf_rd_addr_o` = bits [19:15] for opcodes 0x67, 0x63, 0x03, 0x23, 0x13, 0x33, and only in the first phase-4 cycle with bits [24:20] for opcodes 0x63, 0x23, 0x33; it stays low when that index is 0.
- R6: `exec_valid_o` pulses in phase 1 of the following instruction, carrying the full instruction on `exec_instr_o` and its start address on `exec_pc_o`.
- R7: `rf_we_o` pulses one cycle after `exec_valid_o`, with `rf_wr_addr_o` = the destination, only for legal opcodes that write a result (0x37, 0x17, 0x6F, 0x67, 0x03, 0x13, 0x33) and never for destination 0.
- R8: If `redirect_i` is high while `exec_valid_o` is high, the next cycle is phase 1 at `redirect_pc_i`; the byte fetched in the redirect cycle is discarded.
- R9: For opcodes 0x03 and 0x23, `ls_active_o` is high in phase 4; from the second phase-4 cycle on, the sequencer stays in phase 4 with `mem_addr` frozen until `ls_done_i` is sampled high.
- R10: While `hold` is high, the program counter, phase and pending execute and writeback are unchanged, and `exec_valid_o`, `rf_we_o` and `rf_rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Freeze all state and mask strobes |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_rdata | input | 8 | Byte at `mem_addr`, same cycle |
| phase_o | output | 2 | Current phase minus one |
| dec_rd_o | output | 5 | Destination index, valid in phase 2 |
| dec_legal_o | output | 1 | Opcode legality, valid in phase 2 |
| rf_rd_en_o | output | 1 | Register-file read strobe |
| rf_rd_addr_o | output | 5 | Register-file read index |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wr_addr_o | output | 5 | Register-file write index |
| exec_valid_o | output | 1 | Instruction is being executed this cycle |
| exec_instr_o | output | 32 | Instruction being executed |
| exec_pc_o | output | 32 | Start address of that instruction |
| redirect_i | input | 1 | Taken jump or branch, sampled with `exec_valid_o` |
| redirect_pc_i | input | 32 | Target address |
| ls_active_o | output | 1 | Phase 4 of a load or store |
| ls_done_i | input | 1 | Data access finished |

## Verification
The hardest state to reach is a hold landing on the exact cycle an instruction executes, with its writeback still owed: the pending execute must neither fire nor be lost, and the writeback must appear only after release. The stimulus reaches it by running a load through a multi-cycle stall, releasing the stall, and raising `hold` in the very phase-1 cycle the load executes, then checking that the execute pulse reappears on release and the write strobe follows one cycle later. The redirect path is reached the same way, by watching for the jump's execute pulse and answering with a target in that cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int XLEN = 32;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {PH1 = 2'd0, PH2 = 2'd1, PH3 = 2'd2, PH4 = 2'd3} phase_t;

  localparam logic [6:0] OP_LUI    = 7'h37;
  localparam logic [6:0] OP_AUIPC  = 7'h17;
  localparam logic [6:0] OP_JAL    = 7'h6F;
  localparam logic [6:0] OP_JALR   = 7'h67;
  localparam logic [6:0] OP_BRANCH = 7'h63;
  localparam logic [6:0] OP_LOAD   = 7'h03;
  localparam logic [6:0] OP_STORE  = 7'h23;
  localparam logic [6:0] OP_IMM    = 7'h13;
  localparam logic [6:0] OP_REG    = 7'h33;
  localparam logic [6:0] OP_FENCE  = 7'h0F;
  localparam logic [6:0] OP_SYS    = 7'h73;

  function automatic logic op_legal(input logic [6:0] op);
    case (op)
      OP_LUI, OP_AUIPC, OP_JAL, OP_JALR, OP_BRANCH, OP_LOAD,
      OP_STORE, OP_IMM, OP_REG, OP_FENCE, OP_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_uses_src1(input logic [6:0] op);
    case (op)
      OP_JALR, OP_BRANCH, OP_LOAD, OP_STORE, OP_IMM, OP_REG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_uses_src2(input logic [6:0] op);
    case (op)
      OP_BRANCH, OP_STORE, OP_REG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_writes_dst(input logic [6:0] op);
    case (op)
      OP_LUI, OP_AUIPC, OP_JAL, OP_JALR, OP_LOAD, OP_IMM, OP_REG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_mem(input logic [6:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/fseq_phase_ctrl.sv
module fseq_phase_ctrl
  import fseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            is_mem_i,
  input  logic            ls_done_i,
  input  logic            redir_take_i,
  input  logic [XLEN-1:0] redir_pc_i,
  output phase_t          phase_q,
  output logic [XLEN-1:0] pc_q,
  output logic            p4_seen_q,
  output logic            leave_p4_o
);
  assign leave_p4_o = (phase_q == PH4) && !hold && (p4_seen_q ? ls_done_i : !is_mem_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH1;
      pc_q      <= '0;
      p4_seen_q <= 1'b0;
    end else if (!hold) begin
      case (phase_q)
        PH1: begin
          if (redir_take_i) begin
            pc_q <= redir_pc_i;
          end else begin
            pc_q    <= pc_q + 1'b1;
            phase_q <= PH2;
          end
        end
        PH2: begin
          pc_q    <= pc_q + 1'b1;
          phase_q <= PH3;
        end
        PH3: begin
          pc_q    <= pc_q + 1'b1;
          phase_q <= PH4;
        end
        default: begin
          if (!p4_seen_q) begin
            pc_q <= pc_q + 1'b1;
            if (is_mem_i) p4_seen_q <= 1'b1;
            else          phase_q   <= PH1;
          end else if (ls_done_i) begin
            p4_seen_q <= 1'b0;
            phase_q   <= PH1;
          end
        end
      endcase
    end
  end

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && phase_q == PH2) |=> (phase_q == PH3 && pc_q == $past(pc_q) + 1));

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(pc_q) && $stable(phase_q)));

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_take_i |=> (phase_q == PH1 && pc_q == $past(redir_pc_i)));

  assert_ls_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH4 && p4_seen_q && !ls_done_i) |=> (phase_q == PH4 && $stable(pc_q)));
endmodule

// File: rtl/fseq_byte_asm.sv
module fseq_byte_asm
  import fseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  phase_t          phase_i,
  input  logic            p4_seen_i,
  input  logic            leave_p4_i,
  input  logic            exec_fire_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [7:0]      rdata_i,
  output logic [23:0]     low_o,
  output logic [XLEN-1:0] instr_o,
  output logic [XLEN-1:0] ipc_o,
  output logic            ex_pend_o
);
  localparam int LOW_BYTES = 3;

  logic [7:0]      top_byte_q;
  logic [7:0]      top_byte_now;
  logic [XLEN-1:0] start_pc_q;

  for (genvar k = 0; k < LOW_BYTES; k++) begin : g_low
    always_ff @(posedge clk) begin
      if (!rst_n)                                 low_o[8*k +: 8] <= '0;
      else if (!hold && phase_i == phase_t'(k))   low_o[8*k +: 8] <= rdata_i;
    end
  end

  assign top_byte_now = p4_seen_i ? top_byte_q : rdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_byte_q <= '0;
      start_pc_q <= '0;
      instr_o    <= '0;
      ipc_o      <= '0;
      ex_pend_o  <= 1'b0;
    end else if (!hold) begin
      if (phase_i == PH4 && !p4_seen_i) top_byte_q <= rdata_i;
      if (phase_i == PH1) start_pc_q <= pc_i;
      if (leave_p4_i) begin
        instr_o   <= {top_byte_now, low_o};
        ipc_o     <= start_pc_q;
        ex_pend_o <= 1'b1;
      end else if (exec_fire_i) begin
        ex_pend_o <= 1'b0;
      end
    end
  end

  assert_pend_lands_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    leave_p4_i |=> (ex_pend_o && phase_i == PH1));

  assert_pend_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ex_pend_o));
endmodule

// File: rtl/fseq_rf_sched.sv
module fseq_rf_sched
  import fseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  phase_t           phase_i,
  input  logic             p4_seen_i,
  input  logic [23:0]      low_i,
  input  logic [7:0]       rdata_i,
  input  logic             leave_p4_i,
  input  logic             exec_fire_i,
  output logic [REG_W-1:0] dec_rd_o,
  output logic             dec_legal_o,
  output logic             rd_en_o,
  output logic [REG_W-1:0] rd_addr_o,
  output logic             we_o,
  output logic [REG_W-1:0] wr_addr_o
);
  logic [6:0] op;
  logic       wr_flag_q;
  logic       wb_pend_q;

  assign op          = low_i[6:0];
  assign dec_rd_o    = {rdata_i[3:0], low_i[7]};
  assign dec_legal_o = op_legal(op);

  always_comb begin
    rd_addr_o = '0;
    rd_en_o   = 1'b0;
    case (phase_i)
      PH3: begin
        rd_addr_o = {rdata_i[3:0], low_i[15]};
        rd_en_o   = !hold && op_uses_src1(op) && (rd_addr_o != '0);
      end
      PH4: begin
        rd_addr_o = {rdata_i[0], low_i[23:20]};
        rd_en_o   = !hold && !p4_seen_i && op_uses_src2(op) && (rd_addr_o != '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_flag_q <= 1'b0;
      wr_addr_o <= '0;
      wb_pend_q <= 1'b0;
    end else if (!hold) begin
      if (leave_p4_i) begin
        wr_flag_q <= op_legal(op) && op_writes_dst(op);
        wr_addr_o <= {low_i[11:8], low_i[7]};
      end
      wb_pend_q <= exec_fire_i && wr_flag_q && (wr_addr_o != '0);
    end
  end

  assign we_o = wb_pend_q && !hold;

  assert_wb_not_x0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (wr_addr_o != '0));

  assert_read_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> (phase_i == PH3 || phase_i == PH4));

  assert_write_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (phase_i == PH1 || phase_i == PH2));
endmodule

// File: rtl/byte_fetch_seq.sv
module byte_fetch_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [1:0]        phase_o,
  output logic [4:0]        dec_rd_o,
  output logic              dec_legal_o,
  output logic              rf_rd_en_o,
  output logic [4:0]        rf_rd_addr_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_wr_addr_o,
  output logic              exec_valid_o,
  output logic [31:0]       exec_instr_o,
  output logic [31:0]       exec_pc_o,
  input  logic              redirect_i,
  input  logic [31:0]       redirect_pc_i,
  output logic              ls_active_o,
  input  logic              ls_done_i
);
  phase_t          phase;
  logic [XLEN-1:0] pc;
  logic            p4_seen;
  logic            leave_p4;
  logic            ex_pend;
  logic            exec_fire;
  logic [23:0]     low_bytes;
  logic            is_mem;

  assign is_mem       = op_is_mem(low_bytes[6:0]);
  assign exec_fire    = ex_pend && (phase == PH1) && !hold;
  assign exec_valid_o = exec_fire;
  assign mem_addr     = pc[ADDR_W-1:0];
  assign phase_o      = phase;
  assign ls_active_o  = (phase == PH4) && is_mem;

  fseq_phase_ctrl u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold         (hold),
    .is_mem_i     (is_mem),
    .ls_done_i    (ls_done_i),
    .redir_take_i (exec_fire && redirect_i),
    .redir_pc_i   (redirect_pc_i),
    .phase_q      (phase),
    .pc_q         (pc),
    .p4_seen_q    (p4_seen),
    .leave_p4_o   (leave_p4)
  );

  fseq_byte_asm u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hold),
    .phase_i     (phase),
    .p4_seen_i   (p4_seen),
    .leave_p4_i  (leave_p4),
    .exec_fire_i (exec_fire),
    .pc_i        (pc),
    .rdata_i     (mem_rdata),
    .low_o       (low_bytes),
    .instr_o     (exec_instr_o),
    .ipc_o       (exec_pc_o),
    .ex_pend_o   (ex_pend)
  );

  fseq_rf_sched u_rf (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hold),
    .phase_i     (phase),
    .p4_seen_i   (p4_seen),
    .low_i       (low_bytes),
    .rdata_i     (mem_rdata),
    .leave_p4_i  (leave_p4),
    .exec_fire_i (exec_fire),
    .dec_rd_o    (dec_rd_o),
    .dec_legal_o (dec_legal_o),
    .rd_en_o     (rf_rd_en_o),
    .rd_addr_o   (rf_rd_addr_o),
    .we_o        (rf_we_o),
    .wr_addr_o   (rf_wr_addr_o)
  );

  assert_port_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> !rf_rd_en_o);

  assert_wb_after_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> $past(exec_valid_o));

  assert_hold_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !(exec_valid_o || rf_we_o || rf_rd_en_o));
endmodule

// File: tb/byte_fetch_seq_tb.sv
module byte_fetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [1:0]  phase_o;
  logic [4:0]  dec_rd_o, rf_rd_addr_o, rf_wr_addr_o;
  logic        dec_legal_o, rf_rd_en_o, rf_we_o, exec_valid_o, ls_active_o;
  logic [31:0] exec_instr_o, exec_pc_o;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_pc_i = '0;
  logic        ls_done_i = 1'b0;

  logic [7:0] rom [0:255];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign mem_rdata = rom[mem_addr[7:0]];

  byte_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .phase_o(phase_o), .dec_rd_o(dec_rd_o), .dec_legal_o(dec_legal_o),
    .rf_rd_en_o(rf_rd_en_o), .rf_rd_addr_o(rf_rd_addr_o), .rf_we_o(rf_we_o),
    .rf_wr_addr_o(rf_wr_addr_o), .exec_valid_o(exec_valid_o), .exec_instr_o(exec_instr_o),
    .exec_pc_o(exec_pc_o), .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i),
    .ls_active_o(ls_active_o), .ls_done_i(ls_done_i)
  );

  task automatic put_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) rom[a + i] = w[8*i +: 8];
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "phase", phase_o, 0);
    chk("R1", "addr", mem_addr, 0);
    chk("R1", "exec", exec_valid_o, 0);
    chk("R1", "we", rf_we_o, 0);
    chk("R1", "rd_en", rf_rd_en_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_straight();
    chk("R2", "addr c0", mem_addr, 16'h0000);
    step();
    chk("R3", "phase c1", phase_o, 1);
    chk("R2", "addr c1", mem_addr, 16'h0001);
    chk("R4", "dec_rd", dec_rd_o, 5);
    chk("R4", "legal", dec_legal_o, 1);
    step();
    chk("R3", "phase c2", phase_o, 2);
    chk("R5", "rs1 en", rf_rd_en_o, 1);
    chk("R5", "rs1 idx", rf_rd_addr_o, 1);
    step();
    chk("R3", "phase c3", phase_o, 3);
    chk("R5", "no rs2 for imm", rf_rd_en_o, 0);
    step();
    chk("R3", "phase c4", phase_o, 0);
    chk("R2", "pc+4", mem_addr, 16'h0004);
    chk("R6", "exec", exec_valid_o, 1);
    chk("R6", "instr", exec_instr_o, 32'h00308293);
    chk("R6", "pc", exec_pc_o, 0);
    step();
    chk("R7", "we", rf_we_o, 1);
    chk("R7", "wr idx", rf_wr_addr_o, 5);
    chk("R4", "dec_rd add", dec_rd_o, 6);
    step();
    chk("R5", "add rs1", {rf_rd_en_o, 3'b0, rf_rd_addr_o}, {1'b1, 3'b0, 5'd2});
    step();
    chk("R5", "add rs2", {rf_rd_en_o, 3'b0, rf_rd_addr_o}, {1'b1, 3'b0, 5'd3});
    step();
    chk("R6", "add instr", exec_instr_o, 32'h00310333);
    chk("R6", "add pc", exec_pc_o, 4);
    step();
    chk("R7", "add wr", {rf_we_o, 3'b0, rf_wr_addr_o}, {1'b1, 3'b0, 5'd6});
    step(); step();
    step();
    chk("R6", "lui exec", exec_instr_o, 32'h12345037);
    step();
    chk("R7", "x0 no write", rf_we_o, 0);
    step();
    chk("R5", "rs1 x0 no read", rf_rd_en_o, 0);
    step(); step();
    chk("R2", "addr 16", mem_addr, 16'h0010);
  endtask

  task automatic t_redirect();
    step(); step(); step(); step();
    chk("R6", "jal exec", exec_valid_o, 1);
    chk("R6", "jal instr", exec_instr_o, 32'h000000EF);
    chk("R6", "jal pc", exec_pc_o, 16);
    redirect_i = 1'b1;
    redirect_pc_i = 32'h40;
    step();
    redirect_i = 1'b0;
    chk("R8", "target addr", mem_addr, 16'h0040);
    chk("R8", "phase 1", phase_o, 0);
    chk("R8", "no exec", exec_valid_o, 0);
    chk("R7", "jal wb", {rf_we_o, 3'b0, rf_wr_addr_o}, {1'b1, 3'b0, 5'd1});
    step();
    chk("R8", "target+1", mem_addr, 16'h0041);
  endtask

  task automatic t_ls();
    step();
    chk("R5", "lw rs1", {rf_rd_en_o, 3'b0, rf_rd_addr_o}, {1'b1, 3'b0, 5'd8});
    step();
    chk("R9", "ls active", ls_active_o, 1);
    chk("R9", "addr 43", mem_addr, 16'h0043);
    step();
    chk("R9", "parked", phase_o, 3);
    chk("R9", "addr 44", mem_addr, 16'h0044);
    step();
    chk("R9", "still parked", phase_o, 3);
    chk("R9", "addr kept", mem_addr, 16'h0044);
    chk("R9", "active", ls_active_o, 1);
    ls_done_i = 1'b1;
    step();
    ls_done_i = 1'b0;
    chk("R9", "released", phase_o, 0);
    chk("R6", "lw instr", exec_instr_o, 32'h00042383);
    chk("R6", "lw pc", exec_pc_o, 32'h40);
  endtask

  task automatic t_hold();
    hold = 1'b1;
    #1;
    chk("R10", "exec masked", exec_valid_o, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R10", "addr frozen", mem_addr, 16'h0044);
      chk("R10", "phase frozen", phase_o, 0);
      chk("R10", "we masked", rf_we_o, 0);
    end
    hold = 1'b0;
    #1;
    chk("R10", "exec kept", exec_valid_o, 1);
    step();
    chk("R7", "lw wb", {rf_we_o, 3'b0, rf_wr_addr_o}, {1'b1, 3'b0, 5'd7});
    chk("R4", "illegal flag", dec_legal_o, 0);
    chk("R4", "illegal rd", dec_rd_o, 31);
  endtask

  task automatic t_illegal();
    step();
    chk("R5", "illegal no read", rf_rd_en_o, 0);
    step(); step();
    chk("R6", "illegal exec", exec_instr_o, 32'hFFFFFFFF);
    step();
    chk("R7", "illegal no wb", rf_we_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    put_word(0, 32'h00308293);
    put_word(4, 32'h00310333);
    put_word(8, 32'h12345037);
    put_word(12, 32'h00000013);
    put_word(16, 32'h000000EF);
    put_word(32'h40, 32'h00042383);
    put_word(32'h44, 32'hFFFFFFFF);
    t_reset();
    t_straight();
    t_redirect();
    t_ls();
    t_hold();
    t_illegal();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule